// File: doc/BRIEF.md
# Toggle-Bit Compare PWM Generator

This block produces a pulse-width modulated output from one free-running 16-bit up-counter and one compare register. When the counter reaches the compare value, a service step runs. The step inverts the output and advances the compare register by one of two programmed durations. A self-inverting toggle bit selects the duration: the on-time is added when the bit is 0 and the off-time when it is 1. The bit then flips, so the two durations alternate. There is no period counter. The period is the sum of the two durations, and the duty is the on-time over that sum.

Software sets up a run in three steps. It loads the compare start value, the output start level and the toggle-bit start value with one load strobe. It writes the duration pair with a write strobe. It then sets a control byte and a service enable. The control byte 0x43 selects the toggle mode with a start toggle bit of 1, and 0x42 selects it with a start toggle bit of 0. Generation runs until service is disabled. A new duration pair may be written at any time. It is used from the next service step onward.

Top module: `toggle_pwm`

## Requirements
- R1: While rst_ni is low and after its release, pwm_o, tbit_o, cmp_o and timer_o are all 0.
- R2: A cycle with load_i=1 sets timer_o to 0, cmp_o to init_cmp_i, pwm_o to init_lvl_i and tbit_o to ctrl_i[0] at the next edge. Load takes priority over counting and service.
- R3: With tmr_en_i=1 the timer advances by one every cycle when presc_sel_i=0. When presc_sel_i=1 it advances once every 4 enabled cycles, using a divider that load clears. The timer holds while tmr_en_i=0 and wraps from 0xFFFF to 0.
- R4: A service step happens on a cycle where the timer advances, timer_o equals cmp_o, service is active and load_i=0. A step inverts pwm_o at the next edge. In every other non-load cycle pwm_o holds its level.
- R5: On a step, cmp_o increases by the active on-time when tbit_o=0 and by the active off-time when tbit_o=1. The sum wraps modulo 2^16.
- R6: Every step inverts tbit_o, which always shows the current toggle bit.
- R7: Service is active only when svc_en_i=1, ctrl_i[7:5]=3'b010, ctrl_i[4:2]=3'b000 and ctrl_i[1]=1. Examples are 0x43 and 0x42. Otherwise a match leaves pwm_o, cmp_o and tbit_o unchanged.
- R8: const_wr_i=1 replaces the on-time/off-time pair as one unit. A step in the same cycle as the write still uses the previous pair, and the following step uses the new pair.
- R9: Loaded with pwm_o=1, cmp_o=T1 and toggle bit 1, the steady-state output is low for (T2-T1)·d cycles and high for T1·d cycles, where d is 1 or 4 per presc_sel_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_en_i | input | 1 | Timer run enable |
| presc_sel_i | input | 1 | 0: count every cycle, 1: count every 4th enabled cycle |
| ctrl_i | input | 8 | Control byte: mode [7:5], zero [4:2], toggle select [1], start toggle bit [0] |
| on_time_i | input | 16 | On-time value for a pair write |
| off_time_i | input | 16 | Off-time value for a pair write |
| const_wr_i | input | 1 | Writes the on/off pair |
| load_i | input | 1 | Loads timer, compare, output level and toggle bit |
| init_cmp_i | input | 16 | Compare value applied by load |
| init_lvl_i | input | 1 | Output level applied by load |
| svc_en_i | input | 1 | Service enable |
| pwm_o | output | 1 | PWM output |
| tbit_o | output | 1 | Current toggle bit |
| cmp_o | output | 16 | Current compare value |
| timer_o | output | 16 | Current timer value |

## Verification
The bench writes a new duration pair in the exact cycle a match fires. A design that applied the pair at once would produce a compare value built from the new on-time instead of the old one. It forces a compare addition past 0xFFFF and runs the timer through a full wrap. A design that saturated or carried wrongly would stop toggling or toggle at the wrong count. It offers matches with service disabled and with near-miss control bytes such as 0x63. A loose mode decode would toggle the output there. It also measures the steady high and low run lengths under both prescaler settings, which exposes an off-by-one in the match cycle or a swapped duration choice.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam logic [2:0] MODE_TOGGLE_PWM = 3'b010;

  typedef struct packed {
    logic [2:0] mode;
    logic [2:0] zero;
    logic       tsel;
    logic       tbit;
  } pwm_ctrl_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned TW      = 16,
  parameter int unsigned PRE_DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          en_i,
  input  logic          div_sel_i,
  output logic          tick_o,
  output logic [TW-1:0] timer_o
);
  logic [TW-1:0] timer_q;

  generate
    if (PRE_DIV > 1) begin : g_div
      localparam int unsigned PCW = $clog2(PRE_DIV);
      localparam logic [PCW-1:0] PC_LAST = PCW'(PRE_DIV - 1);
      logic [PCW-1:0] pc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pc_q <= '0;
        else if (load_i) pc_q <= '0;
        else if (en_i)   pc_q <= (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
      end
      assign tick_o = en_i && (!div_sel_i || (pc_q == PC_LAST));
    end else begin : g_nodiv
      logic unused_sel;
      assign unused_sel = div_sel_i;
      assign tick_o = en_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     timer_q <= '0;
    else if (load_i) timer_q <= '0;
    else if (tick_o) timer_q <= timer_q + 1'b1;
  end

  assign timer_o = timer_q;
endmodule

// File: rtl/pwm_service.sv
module pwm_service #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] init_cmp_i,
  input  logic          init_tbit_i,
  input  logic          wr_i,
  input  logic [TW-1:0] on_i,
  input  logic [TW-1:0] off_i,
  input  logic          step_i,
  output logic [TW-1:0] cmp_o,
  output logic          tbit_o,
  output logic [TW-1:0] on_o,
  output logic [TW-1:0] off_o
);
  logic [TW-1:0] cmp_q, on_q, off_q;
  logic          tbit_q;

  // pair written atomically; a step in the write cycle sees the old pair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= '0;
      off_q <= '0;
    end else if (wr_i) begin
      on_q  <= on_i;
      off_q <= off_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      tbit_q <= 1'b0;
    end else if (load_i) begin
      cmp_q  <= init_cmp_i;
      tbit_q <= init_tbit_i;
    end else if (step_i) begin
      cmp_q  <= cmp_q + (tbit_q ? off_q : on_q);
      tbit_q <= ~tbit_q;
    end
  end

  assign cmp_o  = cmp_q;
  assign tbit_o = tbit_q;
  assign on_o   = on_q;
  assign off_o  = off_q;
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic init_lvl_i,
  input  logic step_i,
  output logic pwm_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lvl_q <= 1'b0;
    else if (load_i)  lvl_q <= init_lvl_i;
    else if (step_i)  lvl_q <= ~lvl_q;
  end

  assign pwm_o = lvl_q;
endmodule

// File: rtl/toggle_pwm.sv
module toggle_pwm #(
  parameter int unsigned TW      = 16,
  parameter int unsigned PRE_DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tmr_en_i,
  input  logic          presc_sel_i,
  input  logic [7:0]    ctrl_i,
  input  logic [TW-1:0] on_time_i,
  input  logic [TW-1:0] off_time_i,
  input  logic          const_wr_i,
  input  logic          load_i,
  input  logic [TW-1:0] init_cmp_i,
  input  logic          init_lvl_i,
  input  logic          svc_en_i,
  output logic          pwm_o,
  output logic          tbit_o,
  output logic [TW-1:0] cmp_o,
  output logic [TW-1:0] timer_o
);
  import pwm_pkg::*;

  pwm_ctrl_t     ctrl;
  logic          tick_w, active_w, step_w;
  logic [TW-1:0] timer_w, cmp_w, on_w, off_w;

  assign ctrl     = pwm_ctrl_t'(ctrl_i);
  assign active_w = svc_en_i && (ctrl.mode == MODE_TOGGLE_PWM)
                    && (ctrl.zero == 3'b000) && ctrl.tsel;
  assign step_w   = !load_i && active_w && tick_w && (timer_w == cmp_w);

  pwm_timebase #(.TW(TW), .PRE_DIV(PRE_DIV)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .en_i     (tmr_en_i),
    .div_sel_i(presc_sel_i),
    .tick_o   (tick_w),
    .timer_o  (timer_w)
  );

  pwm_service #(.TW(TW)) u_svc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .init_cmp_i (init_cmp_i),
    .init_tbit_i(ctrl.tbit),
    .wr_i       (const_wr_i),
    .on_i       (on_time_i),
    .off_i      (off_time_i),
    .step_i     (step_w),
    .cmp_o      (cmp_w),
    .tbit_o     (tbit_o),
    .on_o       (on_w),
    .off_o      (off_w)
  );

  pwm_outstage u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .init_lvl_i(init_lvl_i),
    .step_i    (step_w),
    .pwm_o     (pwm_o)
  );

  assign cmp_o   = cmp_w;
  assign timer_o = timer_w;
endmodule

// File: rtl/pwm_sva.sv
module pwm_sva #(
  parameter int unsigned TW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_i,
  input logic          svc_en_i,
  input logic          step_w,
  input logic          tick_w,
  input logic [TW-1:0] timer_o,
  input logic [TW-1:0] cmp_o,
  input logic          tbit_o,
  input logic          pwm_o,
  input logic [TW-1:0] on_w,
  input logic [TW-1:0] off_w
);
  a_r4_pwm_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_w |=> pwm_o != $past(pwm_o));
  a_r4_pwm_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_w && !load_i) |=> $stable(pwm_o));
  a_r5_add_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_w && !tbit_o) |=> cmp_o == $past(cmp_o + on_w));
  a_r5_add_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_w && tbit_o) |=> cmp_o == $past(cmp_o + off_w));
  a_r6_tbit_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_w |=> tbit_o != $past(tbit_o));
  a_r7_idle_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!svc_en_i && !load_i) |=> ($stable(cmp_o) && $stable(tbit_o) && $stable(pwm_o)));
  a_r3_timer_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_w && !load_i && (timer_o == {TW{1'b1}})) |=> timer_o == '0);
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> timer_o == '0);
endmodule

bind toggle_pwm pwm_sva #(.TW(TW)) u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .svc_en_i(svc_en_i),
  .step_w  (step_w),
  .tick_w  (tick_w),
  .timer_o (timer_o),
  .cmp_o   (cmp_o),
  .tbit_o  (tbit_o),
  .pwm_o   (pwm_o),
  .on_w    (on_w),
  .off_w   (off_w)
);

// File: tb/toggle_pwm_tb_top.sv
module toggle_pwm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_en = 0, presc = 0, const_wr = 0, load = 0, init_lvl = 0, svc_en = 0;
  logic [7:0]  ctrl = 8'h00;
  logic [15:0] on_t = 0, off_t = 0, init_cmp = 0;
  logic        pwm, tbit;
  logic [15:0] cmp, timer;

  int errors = 0, checks = 0;
  bit chk_on = 0;

  // reference state
  logic [1:0]  m_pc;
  logic [15:0] m_tmr, m_cmp, m_on, m_off;
  logic        m_tb, m_pwm;

  always #10 clk = ~clk;

  toggle_pwm dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tmr_en_i(tmr_en), .presc_sel_i(presc),
    .ctrl_i(ctrl), .on_time_i(on_t), .off_time_i(off_t), .const_wr_i(const_wr),
    .load_i(load), .init_cmp_i(init_cmp), .init_lvl_i(init_lvl), .svc_en_i(svc_en),
    .pwm_o(pwm), .tbit_o(tbit), .cmp_o(cmp), .timer_o(timer)
  );

  function automatic bit svc_active(logic en, logic [7:0] c);
    return en && (c[7:5] == 3'b010) && (c[4:2] == 3'b000) && c[1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_tmr = 0; m_cmp = 0; m_on = 0; m_off = 0; m_tb = 0; m_pwm = 0;
    end else begin
      logic tick, stp;
      logic [15:0] add;
      tick = tmr_en && (!presc || m_pc == 2'd3);
      stp  = !load && svc_active(svc_en, ctrl) && tick && (m_tmr == m_cmp);
      add  = m_tb ? m_off : m_on;
      if (load) begin
        m_pc = 0; m_tmr = 0; m_cmp = init_cmp; m_tb = ctrl[0]; m_pwm = init_lvl;
      end else begin
        if (tmr_en) m_pc = m_pc + 2'd1;
        if (tick) m_tmr = m_tmr + 16'd1;
        if (stp) begin m_cmp = m_cmp + add; m_tb = ~m_tb; m_pwm = ~m_pwm; end
      end
      if (const_wr) begin m_on = on_t; m_off = off_t; end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_on && rst_n) begin
    chk(timer == m_tmr, "R3 timer", timer, m_tmr);
    chk(pwm == m_pwm, "R4 pwm", pwm, m_pwm);
    chk(cmp == m_cmp, "R5 cmp", cmp, m_cmp);
    chk(tbit == m_tb, "R6 tbit", tbit, m_tb);
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_load(logic [15:0] c0, logic lvl, logic [7:0] cb);
    init_cmp = c0; init_lvl = lvl; ctrl = cb; load = 1;
    @(negedge clk); load = 0;
  endtask

  task automatic wr_pair(logic [15:0] a, logic [15:0] b);
    on_t = a; off_t = b; const_wr = 1;
    @(negedge clk); const_wr = 0;
  endtask

  task automatic wait_match();
    int g = 0;
    while (!(timer == cmp && (!presc || m_pc == 2'd3)) && g < 70000) begin
      @(negedge clk); g++;
    end
  endtask

  task automatic run_len(output int n);
    logic v = pwm;
    n = 0;
    do begin @(negedge clk); n++; end while (pwm == v && n < 5000);
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240611));
    cyc(2);
    // R1 reset values
    chk(pwm == 0 && tbit == 0, "R1 reset pwm/tbit", {pwm, tbit}, 0);
    chk(cmp == 0 && timer == 0, "R1 reset cmp/timer", {cmp, timer}, 0);
    rst_n = 1; cyc(1);
    chk(timer == 0 && cmp == 0, "R1 after release", {cmp, timer}, 0);
    chk_on = 1;

    // R2 load
    tmr_en = 1; svc_en = 1; wr_pair(16'd6, 16'd10);
    do_load(16'd6, 1'b1, 8'h43);
    chk(timer == 0 && cmp == 6 && pwm == 1 && tbit == 1, "R2 load",
        {timer[7:0], cmp[7:0], 7'd0, pwm, 7'd0, tbit}, 32'h00060101);

    // R9 waveform, prescaler 1 then 4
    run_len(n);
    run_len(n); chk(n == 10, "R9 low run d1", n, 10);
    run_len(n); chk(n == 6, "R9 high run d1", n, 6);
    presc = 1; do_load(16'd6, 1'b1, 8'h43);
    run_len(n);
    run_len(n); chk(n == 40, "R9 low run d4", n, 40);
    run_len(n); chk(n == 24, "R9 high run d4", n, 24);
    presc = 0;

    // R8 pair written in the cycle of a step
    wr_pair(16'd10, 16'd20);
    do_load(16'd5, 1'b0, 8'h42);
    wait_match(); wr_pair(16'd100, 16'd200);
    chk(cmp == 16'd15, "R8 old pair used", cmp, 15);
    wait_match(); cyc(1);
    chk(cmp == 16'd215, "R8 new pair used", cmp, 215);

    // R5 compare wrap
    wr_pair(16'hFFFE, 16'd3);
    do_load(16'd3, 1'b0, 8'h42);
    wait_match(); cyc(1);
    chk(cmp == 16'd1 && tbit == 1, "R5 wrap", cmp, 1);

    // R7 inactive codes and disable
    do_load(16'd4, 1'b1, 8'h63); cyc(8);
    chk(pwm == 1 && cmp == 4, "R7 mode 011 ignored", {pwm, cmp}, {1'b1, 16'd4});
    do_load(16'd4, 1'b1, 8'h47); cyc(8);
    chk(pwm == 1 && cmp == 4, "R7 nonzero bits ignored", {pwm, cmp}, {1'b1, 16'd4});
    do_load(16'd4, 1'b1, 8'h41); cyc(8);
    chk(pwm == 1 && cmp == 4, "R7 toggle select clear", {pwm, cmp}, {1'b1, 16'd4});
    svc_en = 0; do_load(16'd4, 1'b0, 8'h43); cyc(8);
    chk(pwm == 0 && cmp == 4 && tbit == 1, "R7 service off", {pwm, cmp}, {1'b0, 16'd4});

    // R3 hold and full wrap (service off)
    tmr_en = 0; cyc(5);
    chk(timer == 16'd8, "R3 hold", timer, 8);
    tmr_en = 1; cyc(65528);
    chk(timer == 16'd0, "R3 wrap", timer, 0);
    svc_en = 1; cyc(5);
    chk(pwm == 1, "R4 match after wrap", pwm, 1);

    // constrained random runs
    for (int s = 0; s < 40; s++) begin
      logic [15:0] t1, t2;
      logic [7:0] cs[4] = '{8'h43, 8'h42, 8'h43, 8'h63};
      t1 = 16'($urandom_range(1, 40));
      t2 = t1 + 16'($urandom_range(1, 40));
      presc = 1'($urandom_range(0, 1));
      svc_en = 1;
      wr_pair(t1, t2 - t1);
      do_load(t1, 1'b1, cs[$urandom_range(0, 3)]);
      for (int c = 0; c < 300; c++) begin
        if ($urandom_range(0, 59) == 0) begin
          on_t = 16'($urandom_range(1, 50)); off_t = 16'($urandom_range(1, 50));
          const_wr = 1;
        end else const_wr = 0;
        if ($urandom_range(0, 79) == 0) svc_en = ~svc_en;
        tmr_en = ($urandom_range(0, 19) != 0);
        @(negedge clk);
      end
      const_wr = 0; tmr_en = 1;
    end

    chk_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule